// File: doc/BRIEF.md
# Port attribute SRAM access engine

This block sits between a host's 8-bit register bus and an external single-port, byte-wide synchronous SRAM that holds attribute bytes for the ports of two attached repeater devices. The host selects a device, a port number from 1 to 13 and a 6-bit attribute offset. It then issues one of three commands. A read fetches a run of 1 to 6 consecutive bytes into six read-data registers. A write stores one held byte into a run of consecutive attribute bytes. A fill writes that held byte into every SRAM location.

The SRAM is shared with an internal statistics updater. Its requests always win. The engine drives the SRAM only in cycles where the updater is not asking for it, and it resumes where it stopped. Every device has 13 pages of 64 bytes, one page per port. Byte `i` of a run lives at SRAM address `{device, port-1, (offset+i) mod 64}`, so a run wraps inside its page.

The sequencer is a state machine with five states. ST_IDLE goes to ST_READ, ST_WRITE or ST_FILL when a command is accepted. ST_READ goes to ST_DRAIN once the last read of the run has been issued. ST_DRAIN returns to ST_IDLE after it captures the last returned byte. ST_WRITE returns to ST_IDLE after the last write of the run. ST_FILL returns to ST_IDLE after the write to the top address.

Top module: `pattr_access_engine`

## Requirements
- R1: After reset, the run-length (0x01), offset (0x20), page (0x21), write-data (0x22) and status (0x24) registers all read 0x00. Reading the command register (0x23) always returns 0x00.
- R2: Register layout. Offset 0x20 holds the attribute offset in bits 5:0, and bits 7:6 read 0. Offset 0x21 holds the device select in bit 4 (0 = first device, 1 = second) and the port in bits 3:0, and bits 7:5 read 0. Offset 0x01 holds the run length in bits 2:0. Offset 0x22 holds all 8 bits of the write byte. Status 0x24 has busy in bit 0, error in bit 1 and fill-done in bit 2.
- R3: Writing 0x01 to bits 1:0 of 0x23 starts a read. Byte `i` of the run is read from `{dev, port-1, (offset+i) mod 64}` (11-bit address) and lands in register 0x10+i. The first byte fetched therefore goes to 0x10.
- R4: A run-length field of 1 to 6 is used as given. A value of 0 is treated as 1 and a value of 7 as 6. Read-data registers beyond the run keep their previous contents.
- R5: Code 0x02 writes the held byte to the N addresses of the run, formed as in R3. All other SRAM locations are left unchanged.
- R6: Code 0x03 writes the held byte to all 2048 SRAM addresses in ascending order. Busy then clears and fill-done is set.
- R7: Reading status clears the error and fill-done bits. If a flag is set in the same cycle as the read that clears it, the set wins.
- R8: Busy reads 1 from the cycle after a command is accepted until the operation ends. Command writes while busy are ignored, and so is code 0x00.
- R9: A read or write command with port 0, 14 or 15 makes no SRAM access, leaves busy at 0 and sets the sticky error bit. Fill does not depend on the port.
- R10: While `upd_req` is high, `sram_cs` is low and `upd_gnt` is high. The engine then continues from the same byte.
- R11: The run length, offset, page and write byte are captured when a command is accepted. Host writes to those registers while busy affect only later commands.
- R12: The SRAM returns read data one cycle after the read strobe. The engine captures it in that cycle even if the updater takes the SRAM in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (clears status flags on 0x24) |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| upd_req | input | 1 | Statistics updater asks for the SRAM |
| upd_gnt | output | 1 | SRAM granted to the updater |
| sram_cs | output | 1 | Engine SRAM strobe |
| sram_we | output | 1 | Engine SRAM write enable |
| sram_addr | output | 11 | Engine SRAM address |
| sram_wdata | output | 8 | Engine SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one cycle after a read strobe |

## Verification
Two events can coincide. A status read that clears a flag can land in the same cycle as the fill's final write, which sets fill-done. The bench starts a fill with no updater traffic, counts exactly 2047 clock edges and reads status in the final fill cycle. It expects busy-only on that read, then fill-done on the next read, then zero. The second coincidence is an updater request arriving while a command is being accepted or while a run is in progress. The bench holds the request high or toggles it pseudo-randomly during reads, writes and command writes. It judges the result by the exact bytes in the read registers and in its SRAM model, and it requires that no strobe from the engine overlaps a request.

// File: rtl/pattr_pkg.sv
package pattr_pkg;

    localparam int HADDR_W = 8;
    localparam int DATA_W  = 8;
    localparam int OFS_W   = 6;
    localparam int PORT_W  = 4;
    localparam int NPORTS  = 13;
    localparam int MAXRUN  = 6;
    localparam int RUN_W   = $clog2(MAXRUN + 1);
    localparam int SADDR_W = 1 + PORT_W + OFS_W;

    localparam logic [HADDR_W-1:0] A_CFG  = 8'h01;
    localparam logic [HADDR_W-1:0] A_RD0  = 8'h10;
    localparam logic [HADDR_W-1:0] A_OFS  = 8'h20;
    localparam logic [HADDR_W-1:0] A_PAGE = 8'h21;
    localparam logic [HADDR_W-1:0] A_WDAT = 8'h22;
    localparam logic [HADDR_W-1:0] A_CMD  = 8'h23;
    localparam logic [HADDR_W-1:0] A_STAT = 8'h24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_WRITE,
        ST_FILL
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_FILL  = 2'd3
    } eng_op_t;

    // Clamp the host's run-length field into 1..MAXRUN
    function automatic logic [RUN_W-1:0] run_len(input logic [RUN_W-1:0] f);
        if (f == '0)
            return RUN_W'(1);
        else if (f > RUN_W'(MAXRUN))
            return RUN_W'(MAXRUN);
        else
            return f;
    endfunction

endpackage

// File: rtl/pattr_addrgen.sv
module pattr_addrgen
    import pattr_pkg::*;
(
    input  logic               dev,
    input  logic [PORT_W-1:0]  port,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [RUN_W-1:0]   idx,
    output logic [SADDR_W-1:0] addr
);

    logic [PORT_W-1:0] page;
    logic [OFS_W-1:0]  col;

    assign page = port - PORT_W'(1);
    assign col  = ofs + OFS_W'(idx);   // wraps inside the 64-byte page
    assign addr = {dev, page, col};

endmodule

// File: rtl/pattr_hostregs.sv
module pattr_hostregs
    import pattr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               busy,
    input  logic               set_err,
    input  logic               set_done,
    input  logic               cap_we,
    input  logic [RUN_W-1:0]   cap_idx,
    input  logic [DATA_W-1:0]  cap_data,
    output logic [RUN_W-1:0]   run_q,
    output logic [OFS_W-1:0]   ofs_q,
    output logic               dev_q,
    output logic [PORT_W-1:0]  port_q,
    output logic [DATA_W-1:0]  wbyte_q,
    output logic               start,
    output eng_op_t            start_op,
    output logic               err_q,
    output logic               done_q
);

    logic [DATA_W-1:0] rd_q [MAXRUN];
    logic              stat_clr;
    logic [DATA_W-1:0] status;

    assign start_op = eng_op_t'(host_wdata[1:0]);
    assign start    = host_wr && (host_addr == A_CMD) && (host_wdata[1:0] != 2'b00) && !busy;
    assign stat_clr = host_rd && (host_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            ofs_q   <= '0;
            dev_q   <= 1'b0;
            port_q  <= '0;
            wbyte_q <= '0;
        end else if (host_wr) begin
            if (host_addr == A_CFG)  run_q   <= host_wdata[RUN_W-1:0];
            if (host_addr == A_OFS)  ofs_q   <= host_wdata[OFS_W-1:0];
            if (host_addr == A_PAGE) begin
                dev_q  <= host_wdata[PORT_W];
                port_q <= host_wdata[PORT_W-1:0];
            end
            if (host_addr == A_WDAT) wbyte_q <= host_wdata;
        end
    end

    // Sticky flags: a set in the same cycle as the clearing read wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            err_q  <= set_err  | (err_q  & ~stat_clr);
            done_q <= set_done | (done_q & ~stat_clr);
        end
    end

    // Read-data registers: data path only, no reset
    for (genvar g = 0; g < MAXRUN; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (cap_we && (cap_idx == RUN_W'(g)))
                rd_q[g] <= cap_data;
        end
    end

    always_comb begin
        status    = '0;
        status[0] = busy;
        status[1] = err_q;
        status[2] = done_q;
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_CFG:   host_rdata = DATA_W'(run_q);
            A_OFS:   host_rdata = DATA_W'(ofs_q);
            A_PAGE:  host_rdata = DATA_W'({dev_q, port_q});
            A_WDAT:  host_rdata = wbyte_q;
            A_STAT:  host_rdata = status;
            default: host_rdata = '0;
        endcase
        for (int i = 0; i < MAXRUN; i++) begin
            if (host_addr == A_RD0 + HADDR_W'(i))
                host_rdata = rd_q[i];
        end
    end

endmodule

// File: rtl/pattr_seq.sv
module pattr_seq
    import pattr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  eng_op_t            start_op,
    input  logic [RUN_W-1:0]   run,
    input  logic [OFS_W-1:0]   ofs,
    input  logic               dev,
    input  logic [PORT_W-1:0]  port,
    input  logic [DATA_W-1:0]  wbyte,
    input  logic               upd_req,
    output logic               upd_gnt,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               sram_cs,
    output logic               sram_we,
    output logic [SADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    output logic               busy,
    output logic               set_err,
    output logic               set_done,
    output logic               cap_we,
    output logic [RUN_W-1:0]   cap_idx,
    output logic [DATA_W-1:0]  cap_data
);

    eng_state_t st_q, st_nx;

    logic               gnt;
    logic               port_bad;
    logic               accept;
    logic               last_run;
    logic               fill_last;
    logic               op_dev_q;
    logic [PORT_W-1:0]  op_port_q;
    logic [OFS_W-1:0]   op_ofs_q;
    logic [DATA_W-1:0]  op_wbyte_q;
    logic [RUN_W-1:0]   op_len_q;
    logic [RUN_W-1:0]   idx_q;
    logic [SADDR_W-1:0] fill_q;
    logic               cap_vld_q;
    logic [RUN_W-1:0]   cap_idx_q;
    logic [SADDR_W-1:0] run_addr;

    assign gnt       = !upd_req;
    assign upd_gnt   = upd_req;
    assign port_bad  = (port == '0) || (port > PORT_W'(NPORTS));
    assign accept    = (st_q == ST_IDLE) && start && ((start_op == OP_FILL) || !port_bad);
    assign last_run  = (idx_q == op_len_q - RUN_W'(1));
    assign fill_last = &fill_q;

    pattr_addrgen u_addr (
        .dev  (op_dev_q),
        .port (op_port_q),
        .ofs  (op_ofs_q),
        .idx  (idx_q),
        .addr (run_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (start_op)
                        OP_READ:  st_nx = ST_READ;
                        OP_WRITE: st_nx = ST_WRITE;
                        OP_FILL:  st_nx = ST_FILL;
                        default:  st_nx = ST_IDLE;
                    endcase
                end
            end
            ST_READ:  if (gnt && last_run)  st_nx = ST_DRAIN;
            ST_DRAIN: st_nx = ST_IDLE;
            ST_WRITE: if (gnt && last_run)  st_nx = ST_IDLE;
            ST_FILL:  if (gnt && fill_last) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Operand capture and progress counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_dev_q   <= 1'b0;
            op_port_q  <= PORT_W'(1);
            op_ofs_q   <= '0;
            op_wbyte_q <= '0;
            op_len_q   <= RUN_W'(1);
            idx_q      <= '0;
            fill_q     <= '0;
            cap_vld_q  <= 1'b0;
            cap_idx_q  <= '0;
        end else begin
            cap_vld_q <= (st_q == ST_READ) && gnt;
            cap_idx_q <= idx_q;
            if (accept) begin
                op_dev_q   <= dev;
                op_port_q  <= port;
                op_ofs_q   <= ofs;
                op_wbyte_q <= wbyte;
                op_len_q   <= run_len(run);
                idx_q      <= '0;
                fill_q     <= '0;
            end else if (gnt && ((st_q == ST_READ) || (st_q == ST_WRITE))) begin
                idx_q <= idx_q + RUN_W'(1);
            end else if (gnt && (st_q == ST_FILL)) begin
                fill_q <= fill_q + SADDR_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        sram_cs    = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = '0;
        sram_wdata = op_wbyte_q;
        set_done   = 1'b0;
        busy       = (st_q != ST_IDLE);
        set_err    = (st_q == ST_IDLE) && start && (start_op != OP_FILL) && port_bad;
        cap_we     = cap_vld_q;
        cap_idx    = cap_idx_q;
        cap_data   = sram_rdata;
        unique case (st_q)
            ST_READ: begin
                sram_cs   = gnt;
                sram_addr = run_addr;
            end
            ST_WRITE: begin
                sram_cs   = gnt;
                sram_we   = gnt;
                sram_addr = run_addr;
            end
            ST_FILL: begin
                sram_cs   = gnt;
                sram_we   = gnt;
                sram_addr = fill_q;
                set_done  = gnt && fill_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pattr_access_engine.sv
module pattr_access_engine
    import pattr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               upd_req,
    output logic               upd_gnt,
    output logic               sram_cs,
    output logic               sram_we,
    output logic [SADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    input  logic [DATA_W-1:0]  sram_rdata
);

    logic              busy;
    logic              set_err;
    logic              set_done;
    logic              cap_we;
    logic [RUN_W-1:0]  cap_idx;
    logic [DATA_W-1:0] cap_data;
    logic [RUN_W-1:0]  run_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              dev_q;
    logic [PORT_W-1:0] port_q;
    logic [DATA_W-1:0] wbyte_q;
    logic              start;
    eng_op_t           start_op;
    logic              err_q;
    logic              done_q;

    pattr_hostregs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .busy       (busy),
        .set_err    (set_err),
        .set_done   (set_done),
        .cap_we     (cap_we),
        .cap_idx    (cap_idx),
        .cap_data   (cap_data),
        .run_q      (run_q),
        .ofs_q      (ofs_q),
        .dev_q      (dev_q),
        .port_q     (port_q),
        .wbyte_q    (wbyte_q),
        .start      (start),
        .start_op   (start_op),
        .err_q      (err_q),
        .done_q     (done_q)
    );

    pattr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (start_op),
        .run        (run_q),
        .ofs        (ofs_q),
        .dev        (dev_q),
        .port       (port_q),
        .wbyte      (wbyte_q),
        .upd_req    (upd_req),
        .upd_gnt    (upd_gnt),
        .sram_rdata (sram_rdata),
        .sram_cs    (sram_cs),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .busy       (busy),
        .set_err    (set_err),
        .set_done   (set_done),
        .cap_we     (cap_we),
        .cap_idx    (cap_idx),
        .cap_data   (cap_data)
    );

endmodule

// File: rtl/pattr_access_engine_chk.sv
module pattr_access_engine_chk
    import pattr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [HADDR_W-1:0] host_addr,
    input logic [1:0]         cmd_code,
    input logic               host_wr,
    input logic               host_rd,
    input logic               upd_req,
    input logic               upd_gnt,
    input logic               sram_cs,
    input logic               sram_we,
    input logic [PORT_W-1:0]  addr_page,
    input logic               busy,
    input logic [PORT_W-1:0]  port_q,
    input logic               err_q,
    input logic               done_q,
    input logic               set_done
);

    assert_updater_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |-> (!sram_cs && upd_gnt));

    assert_access_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs |-> busy);

    assert_bad_port_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_addr == A_CMD) && ((cmd_code == 2'd1) || (cmd_code == 2'd2)) && !busy
         && ((port_q == '0) || (port_q > PORT_W'(NPORTS))))
        |=> (!busy && err_q));

    assert_done_from_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy));

    assert_read_page_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_cs && !sram_we) |-> (addr_page < PORT_W'(NPORTS)));

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_addr == A_STAT) && set_done) |=> done_q);

endmodule

bind pattr_access_engine pattr_access_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .cmd_code  (host_wdata[1:0]),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .upd_req   (upd_req),
    .upd_gnt   (upd_gnt),
    .sram_cs   (sram_cs),
    .sram_we   (sram_we),
    .addr_page (sram_addr[9:6]),
    .busy      (busy),
    .port_q    (port_q),
    .err_q     (err_q),
    .done_q    (done_q),
    .set_done  (set_done)
);

// File: tb/pattr_access_engine_tb.sv
`timescale 1ns/1ps
module pattr_access_engine_tb;
    import pattr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  host_addr;
    logic [7:0]  host_wdata;
    logic        host_wr;
    logic        host_rd;
    logic [7:0]  host_rdata;
    logic        upd_req;
    logic        upd_gnt;
    logic        sram_cs;
    logic        sram_we;
    logic [10:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [7:0]  sram_rdata;

    always #2.5 clk = ~clk;

    pattr_access_engine u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .upd_req(upd_req), .upd_gnt(upd_gnt), .sram_cs(sram_cs), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    int total = 0;
    int bad   = 0;
    int cs_count    = 0;
    int clash_count = 0;
    int upd_mode    = 0;
    logic preload_req = 1'b0;
    logic [7:0] mem [2048];

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 37) + (a >> 8)) ^ 8'h5A);
    endfunction

    function automatic int at(input int dev, input int port, input int ofs);
        return dev * 1024 + (port - 1) * 64 + (ofs % 64);
    endfunction

    // SRAM model, one-cycle read latency
    always @(posedge clk) begin
        if (preload_req) begin
            for (int i = 0; i < 2048; i++) mem[i] <= pat(i);
        end else if (sram_cs) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata     <= mem[sram_addr];
        end
        if (sram_cs) cs_count++;
        if (sram_cs && upd_req) clash_count++;
    end

    // Updater request driver
    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        upd_req = 1'b0;
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            upd_req = (upd_mode == 2) || ((upd_mode == 1) && lf[0] && lf[3]);
        end
    end

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic put_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic get_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int k;
        k = 0;
        do begin
            get_reg(A_STAT, s);
            k++;
        end while (s[0] && (k < 20000));
    endtask

    task automatic setup(input int dev, input int port, input int ofs, input int n);
        put_reg(A_PAGE, 8'((dev << 4) | port));
        put_reg(A_OFS, 8'(ofs));
        put_reg(A_CFG, 8'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] keep1;
        int c0;
        int a;
        rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        get_reg(A_CFG, v);  check8("R1 cfg", v, 8'h00);
        get_reg(A_OFS, v);  check8("R1 ofs", v, 8'h00);
        get_reg(A_PAGE, v); check8("R1 page", v, 8'h00);
        get_reg(A_WDAT, v); check8("R1 wdata", v, 8'h00);
        get_reg(A_STAT, v); check8("R1 status", v, 8'h00);
        get_reg(A_CMD, v);  check8("R1 cmd", v, 8'h00);

        // R2 layout and reserved bits
        put_reg(A_OFS, 8'hFF);  get_reg(A_OFS, v);  check8("R2 ofs", v, 8'h3F);
        put_reg(A_PAGE, 8'hFF); get_reg(A_PAGE, v); check8("R2 page", v, 8'h1F);
        put_reg(A_CFG, 8'hFF);  get_reg(A_CFG, v);  check8("R2 cfg", v, 8'h07);
        put_reg(A_WDAT, 8'hA7); get_reg(A_WDAT, v); check8("R2 wdata", v, 8'hA7);

        // R8 code 0 is ignored
        put_reg(A_CMD, 8'h00); get_reg(A_STAT, v); check8("R8 nop", v, 8'h00);

        // R6 R7 fill with a status read in its final cycle
        put_reg(A_WDAT, 8'hA5);
        c0 = cs_count;
        put_reg(A_CMD, 8'h03);
        repeat (2047) @(posedge clk);
        get_reg(A_STAT, v); check8("R7 read in last fill cycle", v, 8'h01);
        get_reg(A_STAT, v); check8("R7 done survives clear", v, 8'h04);
        get_reg(A_STAT, v); check8("R7 done cleared", v, 8'h00);
        check_int("R6 fill strobes", cs_count - c0, 2048);
        begin
            int wrong;
            wrong = 0;
            for (int i = 0; i < 2048; i++) if (mem[i] !== 8'hA5) wrong++;
            check_int("R6 fill contents", wrong, 0);
        end

        // Preload pattern
        @(negedge clk) preload_req = 1'b1;
        @(negedge clk) preload_req = 1'b0;

        // R3 R12 read sweep with updater contention
        upd_mode = 1;
        for (int dev = 0; dev < 2; dev++) begin
            for (int port = 1; port <= 13; port++) begin
                for (int k = 0; k < 4; k++) begin
                    int ofs;
                    ofs = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 60 : 63;
                    for (int n = 1; n <= 6; n++) begin
                        setup(dev, port, ofs, n);
                        put_reg(A_CMD, 8'h01);
                        wait_idle();
                        for (int i = 0; i < n; i++) begin
                            get_reg(8'(A_RD0 + 8'(i)), v);
                            check8("R3 R12 read byte", v, pat(at(dev, port, ofs + i)));
                        end
                    end
                end
            end
        end
        upd_mode = 0;

        // R4 clamp: field 0 reads one byte only
        setup(0, 3, 0, 6); put_reg(A_CMD, 8'h01); wait_idle();
        setup(0, 4, 0, 0); put_reg(A_CMD, 8'h01); wait_idle();
        get_reg(A_RD0, v);        check8("R4 len0 byte0", v, pat(at(0, 4, 0)));
        get_reg(A_RD0 + 8'd1, v); check8("R4 len0 byte1 kept", v, pat(at(0, 3, 1)));
        keep1 = pat(at(0, 4, 0));

        // R4 R5 clamp: field 7 writes six bytes
        put_reg(A_WDAT, 8'hE7);
        setup(0, 5, 10, 7); put_reg(A_CMD, 8'h02); wait_idle();
        for (int i = 9; i <= 16; i++)
            check8("R4 R5 len7 write", mem[at(0, 5, i)], (i >= 10 && i <= 15) ? 8'hE7 : pat(at(0, 5, i)));

        // R5 write wraps inside the page
        put_reg(A_WDAT, 8'h5C);
        setup(1, 13, 62, 3); put_reg(A_CMD, 8'h02); wait_idle();
        check8("R5 wrap 62", mem[at(1, 13, 62)], 8'h5C);
        check8("R5 wrap 63", mem[at(1, 13, 63)], 8'h5C);
        check8("R5 wrap 0", mem[at(1, 13, 0)], 8'h5C);
        check8("R5 untouched 1", mem[at(1, 13, 1)], pat(at(1, 13, 1)));
        check8("R5 untouched 61", mem[at(1, 13, 61)], pat(at(1, 13, 61)));
        check8("R5 next page", mem[at(0, 1, 0) + 1024 - 1024], pat(0));

        // R9 invalid ports
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 0 : (k == 1) ? 14 : 15;
            setup(k & 1, p, 4, 2);
            c0 = cs_count;
            put_reg(A_CMD, (k == 1) ? 8'h02 : 8'h01);
            get_reg(A_STAT, v); check8("R9 error status", v, 8'h02);
            get_reg(A_STAT, v); check8("R7 error cleared", v, 8'h00);
            check_int("R9 no access", cs_count - c0, 0);
        end
        get_reg(A_RD0, v); check8("R9 read regs kept", v, keep1);

        // R8 R10 R11 stall, ignored command, captured operands
        upd_mode = 2;
        put_reg(A_WDAT, 8'h11);
        setup(0, 2, 7, 2);
        c0 = cs_count;
        put_reg(A_CMD, 8'h02);
        get_reg(A_STAT, v); check8("R8 busy while stalled", v, 8'h01);
        put_reg(A_WDAT, 8'h22);
        setup(0, 2, 20, 1);
        put_reg(A_CMD, 8'h01);
        check_int("R10 no strobe under request", cs_count - c0, 0);
        upd_mode = 0;
        wait_idle();
        check8("R11 captured byte 7", mem[at(0, 2, 7)], 8'h11);
        check8("R11 captured byte 8", mem[at(0, 2, 8)], 8'h11);
        check8("R11 len captured", mem[at(0, 2, 9)], pat(at(0, 2, 9)));
        check8("R8 ignored read", mem[at(0, 2, 20)], pat(at(0, 2, 20)));
        get_reg(A_RD0, v); check8("R8 ignored read regs", v, keep1);
        get_reg(A_WDAT, v); check8("R11 posted wdata", v, 8'h22);
        put_reg(A_CMD, 8'h02); wait_idle();
        a = at(0, 2, 20);
        check8("R11 next command uses new byte", mem[a], 8'h22);
        check8("R11 next command length", mem[a + 1], pat(a + 1));

        check_int("R10 clashes", clash_count, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule